// File: doc/BRIEF.md
# Strobed Byte Port with Four-Phase Handshake

This block moves one byte at a time between the chip and an external partner over an 8-bit data bus and two control wires. The control wires are a data-available strobe, active low, and a ready line, active high. A static mode bit selects the direction. As a receiver, the port takes a byte when the partner pulls the strobe low, and it answers on the ready line. As a sender, the port drives a byte, then lowers the strobe and follows the partner's ready line through a full four-phase interlock.

The internal side has a write port that reports busy and a sticky rejection flag, and a read port that reports data-valid. Both handshake inputs are asynchronous to the system clock, so they pass through a synchronizer of configurable depth. The incoming data bus goes through a matching pipeline, so the byte that is captured is the one present when the strobe was first seen low. Each finished interlock gives a single-cycle done pulse that the surrounding logic can use as an interrupt request.

Top module: `hs_byte_port`

## Requirements
- R1: After reset, data-valid, busy, the rejection flag and done are low, and the outgoing strobe is high. In receive mode the ready output is high. In send mode the ready output is low and the bus output enable is high.
- R2: In receive mode, the port captures the byte that sits on the data inputs at the first clock edge that samples the strobe low (zero setup, one edge of hold). Read-data shows it and data-valid rises at the third edge after the strobe falls, with the default two-stage synchronizer.
- R3: In receive mode, ready drops in the same cycle that data-valid rises. It rises again only once both of these hold: the synchronized strobe is high, and the byte has been read.
- R4: Every completed interlock yields a done pulse exactly one cycle wide. In receive mode it comes in the cycle ready rises. In send mode it comes in the cycle busy falls.
- R5: A read strobe with data-valid high clears data-valid in the next cycle. A read strobe with data-valid low changes nothing at the ports.
- R6: In send mode, an accepted write drives the byte onto the data outputs in the next cycle. The strobe output falls no earlier than one cycle later.
- R7: In send mode, the strobe output stays low until the synchronized ready is seen low, then rises. Busy stays high from the write until the synchronized ready is seen high again.
- R8: A write while busy is rejected. The data outputs keep their value and the rejection flag sets. The flag stays set until the clear input is pulsed.
- R9: The direction is isolated by mode. In receive mode, writes leave busy low, the strobe output high and the bus undriven. In send mode, the incoming strobe leaves data-valid, ready and done low.
- R10: In send mode, the strobe output is not lowered while the synchronized ready is low. It falls three edges after ready is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_mode | input | 1 | Static direction: 1 = send, 0 = receive |
| pin_dav_n_i | input | 1 | Incoming data-available strobe, active low (receive mode) |
| pin_rdy_o | output | 1 | Ready answer to the sender (receive mode) |
| pin_dav_n_o | output | 1 | Outgoing data-available strobe, active low (send mode) |
| pin_rdy_i | input | 1 | Ready from the receiver (send mode) |
| pin_data_i | input | DATA_W | Incoming data bus |
| pin_data_o | output | DATA_W | Outgoing data bus |
| pin_data_oe | output | 1 | Output enable for the data bus |
| cpu_wr_en | input | 1 | Write strobe for a byte to send |
| cpu_wr_data | input | DATA_W | Byte to send |
| cpu_busy | output | 1 | Send interlock in progress |
| cpu_wr_err | output | 1 | Sticky flag: a write was rejected |
| cpu_err_clr | input | 1 | Clears the rejection flag |
| cpu_rd_en | input | 1 | Read strobe, consumes the received byte |
| cpu_rd_data | output | DATA_W | Last received byte |
| cpu_rd_valid | output | 1 | A received byte is waiting |
| xfer_done | output | 1 | One-cycle pulse at the end of each interlock |

## Verification
Suppose the receive side held a wrong state, such as a buffer that claims to be empty while it is full. Ready would rise too early, within a cycle, and the next strobe would overwrite an unread byte. The bench sees this because it compares ready against its computed release cycle on every clock. Suppose the capture pipeline were misaligned. The bench changes the data bus one cycle after the strobe, so such a fault shows in read-data at the third edge. A send state stuck or advanced by one step moves the strobe or busy edge by at least one cycle against the arithmetic schedule, and the bench checks the strobe, busy and done every cycle of each interlock.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  typedef enum logic {
    RX_OPEN = 1'b0,
    RX_HELD = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_SETUP   = 2'd1,
    TX_STROBE  = 2'd2,
    TX_RELEASE = 2'd3
  } tx_state_e;

  // high-to-low transition between two consecutive samples
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // receive side may raise ready again: strobe released and byte consumed
  function automatic logic may_reopen(input logic dav_n_s, input logic full);
    return dav_n_s & ~full;
  endfunction

  // send-side sequencing on the synchronized ready level
  function automatic tx_state_e tx_next(input tx_state_e cur, input logic accept,
                                        input logic rdy_s);
    tx_state_e nxt;
    nxt = cur;
    unique case (cur)
      TX_IDLE:    if (accept) nxt = TX_SETUP;
      TX_SETUP:   if (rdy_s)  nxt = TX_STROBE;
      TX_STROBE:  if (!rdy_s) nxt = TX_RELEASE;
      TX_RELEASE: if (rdy_s)  nxt = TX_IDLE;
      default:    nxt = TX_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/hbp_sync.sv
`timescale 1ns/1ps
module hbp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hbp_rx.sv
`timescale 1ns/1ps
module hbp_rx
  import hbp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dav_n_a,
  input  logic [DATA_W-1:0] data_a,
  input  logic              rd_en,
  output logic              rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              cap_evt
);

  localparam int             SW       = DATA_W + 1;
  localparam logic [SW-1:0]  SYNC_RST = {1'b1, {DATA_W{1'b0}}};

  logic [SW-1:0]     s_q;
  logic              dav_s;
  logic [DATA_W-1:0] data_s;
  logic              dav_prev_q;
  rx_state_e         state_q;
  logic              full_q;
  logic              reopen_evt;

  // strobe and data travel the same pipeline, so the captured byte is the
  // one sampled together with the first low strobe
  hbp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dav_n_a, data_a}),
    .q     (s_q)
  );

  assign {dav_s, data_s} = s_q;

  assign cap_evt    = en && (state_q == RX_OPEN) && fell(dav_prev_q, dav_s);
  assign reopen_evt = en && (state_q == RX_HELD) && may_reopen(dav_s, full_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_prev_q <= 1'b1;
      state_q    <= RX_OPEN;
      full_q     <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
    end else begin
      dav_prev_q <= dav_s;
      done       <= reopen_evt;
      if (!en)             state_q <= RX_OPEN;
      else if (cap_evt)    state_q <= RX_HELD;
      else if (reopen_evt) state_q <= RX_OPEN;
      if (cap_evt) begin
        full_q  <= 1'b1;
        rd_data <= data_s;
      end else if (rd_en) begin
        full_q  <= 1'b0;
      end
    end
  end

  assign rdy      = en && (state_q == RX_OPEN);
  assign rd_valid = full_q;

endmodule

// File: rtl/hbp_tx.sv
`timescale 1ns/1ps
module hbp_tx
  import hbp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rdy_a,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  output logic              dav_n,
  output logic [DATA_W-1:0] data_o,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic              accept_evt,
  output logic              reject_evt
);

  logic [0:0] rdy_s;
  tx_state_e  state_q;
  tx_state_e  state_d;

  hbp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rdy_a),
    .q     (rdy_s)
  );

  assign accept_evt = en && wr_en && (state_q == TX_IDLE);
  assign reject_evt = en && wr_en && (state_q != TX_IDLE);
  assign state_d    = tx_next(state_q, accept_evt, rdy_s[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      data_o  <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= en ? state_d : TX_IDLE;
      done    <= en && (state_q == TX_RELEASE) && (state_d == TX_IDLE);
      if (accept_evt) data_o <= wr_data;
      if (reject_evt)   err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign dav_n = (state_q != TX_STROBE);
  assign busy  = (state_q != TX_IDLE);

endmodule

// File: rtl/hs_byte_port.sv
`timescale 1ns/1ps
module hs_byte_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_out_mode,
  input  logic              pin_dav_n_i,
  output logic              pin_rdy_o,
  output logic              pin_dav_n_o,
  input  logic              pin_rdy_i,
  input  logic [DATA_W-1:0] pin_data_i,
  output logic [DATA_W-1:0] pin_data_o,
  output logic              pin_data_oe,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              cpu_busy,
  output logic              cpu_wr_err,
  input  logic              cpu_err_clr,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              cpu_rd_valid,
  output logic              xfer_done
);

  // named internal events, brought out for the checker
  logic rx_cap_evt;
  logic rx_done;
  logic tx_accept_evt;
  logic tx_reject_evt;
  logic tx_done;

  hbp_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!cfg_out_mode),
    .dav_n_a  (pin_dav_n_i),
    .data_a   (pin_data_i),
    .rd_en    (cpu_rd_en),
    .rdy      (pin_rdy_o),
    .rd_data  (cpu_rd_data),
    .rd_valid (cpu_rd_valid),
    .done     (rx_done),
    .cap_evt  (rx_cap_evt)
  );

  hbp_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_out_mode),
    .rdy_a      (pin_rdy_i),
    .wr_en      (cpu_wr_en),
    .wr_data    (cpu_wr_data),
    .err_clr    (cpu_err_clr),
    .dav_n      (pin_dav_n_o),
    .data_o     (pin_data_o),
    .busy       (cpu_busy),
    .err        (cpu_wr_err),
    .done       (tx_done),
    .accept_evt (tx_accept_evt),
    .reject_evt (tx_reject_evt)
  );

  assign pin_data_oe = cfg_out_mode;
  assign xfer_done   = rx_done | tx_done;

endmodule

// File: rtl/hs_byte_port_chk.sv
`timescale 1ns/1ps
module hs_byte_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_out_mode,
  input logic              pin_rdy_o,
  input logic              pin_dav_n_o,
  input logic [DATA_W-1:0] pin_data_o,
  input logic              pin_data_oe,
  input logic              cpu_busy,
  input logic              cpu_wr_err,
  input logic              cpu_err_clr,
  input logic              cpu_rd_en,
  input logic              cpu_rd_valid,
  input logic              xfer_done,
  input logic              rx_cap_evt,
  input logic              tx_reject_evt
);

  p_cap_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap_evt |=> cpu_rd_valid && !pin_rdy_o);

  p_rdy_low_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_valid |-> !pin_rdy_o);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_en && cpu_rd_valid |=> !cpu_rd_valid);

  p_data_before_dav_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_dav_n_o) |-> $stable(pin_data_o) && cpu_busy);

  p_idle_dav_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> pin_dav_n_o);

  p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reject_evt |=> cpu_wr_err && $stable(pin_data_o));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_err && !cpu_err_clr |=> cpu_wr_err);

  p_rx_mode_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out_mode |-> !cpu_busy && pin_dav_n_o && !pin_data_oe);

  p_tx_mode_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_mode |-> !cpu_rd_valid && !pin_rdy_o);

  p_tx_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && cfg_out_mode |-> !cpu_busy && $past(cpu_busy));

endmodule

bind hs_byte_port hs_byte_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_out_mode  (cfg_out_mode),
  .pin_rdy_o     (pin_rdy_o),
  .pin_dav_n_o   (pin_dav_n_o),
  .pin_data_o    (pin_data_o),
  .pin_data_oe   (pin_data_oe),
  .cpu_busy      (cpu_busy),
  .cpu_wr_err    (cpu_wr_err),
  .cpu_err_clr   (cpu_err_clr),
  .cpu_rd_en     (cpu_rd_en),
  .cpu_rd_valid  (cpu_rd_valid),
  .xfer_done     (xfer_done),
  .rx_cap_evt    (rx_cap_evt),
  .tx_reject_evt (tx_reject_evt)
);

// File: tb/hs_byte_port_tb_top.sv
`timescale 1ns/1ps
module hs_byte_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_out_mode;
  logic       pin_dav_n_i;
  logic       pin_rdy_o;
  logic       pin_dav_n_o;
  logic       pin_rdy_i;
  logic [7:0] pin_data_i;
  logic [7:0] pin_data_o;
  logic       pin_data_oe;
  logic       cpu_wr_en;
  logic [7:0] cpu_wr_data;
  logic       cpu_busy;
  logic       cpu_wr_err;
  logic       cpu_err_clr;
  logic       cpu_rd_en;
  logic [7:0] cpu_rd_data;
  logic       cpu_rd_valid;
  logic       xfer_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  hs_byte_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_out_mode(cfg_out_mode),
    .pin_dav_n_i(pin_dav_n_i), .pin_rdy_o(pin_rdy_o), .pin_dav_n_o(pin_dav_n_o),
    .pin_rdy_i(pin_rdy_i), .pin_data_i(pin_data_i), .pin_data_o(pin_data_o),
    .pin_data_oe(pin_data_oe), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_busy(cpu_busy), .cpu_wr_err(cpu_wr_err), .cpu_err_clr(cpu_err_clr),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_rd_valid(cpu_rd_valid),
    .xfer_done(xfer_done)
  );

  task automatic chk_b(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_v(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; cfg_out_mode = mode;
    pin_dav_n_i = 1'b1; pin_rdy_i = 1'b1; pin_data_i = 8'h00;
    cpu_wr_en = 1'b0; cpu_wr_data = 8'h00; cpu_err_clr = 1'b0; cpu_rd_en = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk_b("R1 rd_valid", cpu_rd_valid, 1'b0);
    chk_b("R1 busy", cpu_busy, 1'b0);
    chk_b("R1 err", cpu_wr_err, 1'b0);
    chk_b("R1 done", xfer_done, 1'b0);
    chk_b("R1 dav_o", pin_dav_n_o, 1'b1);
    chk_b("R1 rdy_o", pin_rdy_o, !mode);
    chk_b("R1 oe", pin_data_oe, mode);
  endtask

  // receive one byte; k = extra cycles before the read
  task automatic rx_xfer(input logic [7:0] v, input int k);
    int r, rise;
    pin_data_i = v; pin_dav_n_i = 1'b0;
    tick();
    pin_data_i = ~v;                       // only one edge of hold given
    chk_b("R3 rdy before capture", pin_rdy_o, 1'b1);
    tick();
    chk_b("R2 not early", cpu_rd_valid, 1'b0);
    tick();
    chk_b("R2 valid at third edge", cpu_rd_valid, 1'b1);
    chk_v("R2 captured byte", cpu_rd_data, v);
    pin_dav_n_i = 1'b1;
    r    = 3 + k;
    rise = (r + 2 > 6) ? r + 2 : 6;
    for (int n = 3; n <= rise + 1; n++) begin
      chk_b("R3 ready schedule", pin_rdy_o, n >= rise);
      chk_b("R4 rx done pulse", xfer_done, n == rise);
      chk_b("R5 valid until read", cpu_rd_valid, n <= r);
      if (n <= r) chk_v("R3 byte held", cpu_rd_data, v);
      if (n == r)     cpu_rd_en = 1'b1;
      if (n == r + 1) cpu_rd_en = 1'b0;
      tick();
    end
  endtask

  // send one byte; k = receiver delay to drop ready, j = delay to raise it
  task automatic tx_xfer(input logic [7:0] v, input int k, input int j);
    int a, b;
    cpu_wr_en = 1'b1; cpu_wr_data = v;
    tick();
    cpu_wr_en = 1'b0; cpu_wr_data = ~v;
    chk_b("R6 busy after write", cpu_busy, 1'b1);
    chk_v("R6 data driven", pin_data_o, v);
    chk_b("R6 dav held off", pin_dav_n_o, 1'b1);
    tick();
    a = 2 + k;
    b = a + 3 + j;
    for (int n = 2; n <= b + 4; n++) begin
      chk_b("R7 dav schedule", pin_dav_n_o, !(n <= a + 2));
      chk_b("R7 busy schedule", cpu_busy, n <= b + 2);
      chk_b("R4 tx done pulse", xfer_done, n == b + 3);
      chk_v("R6 data stable", pin_data_o, v);
      if (n == a) pin_rdy_i = 1'b0;
      if (n == b) pin_rdy_i = 1'b1;
      tick();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    finish_run();
  end

  initial begin : main
    // ---------------- receive mode ----------------
    do_reset(1'b0);
    // R5: read with nothing waiting
    cpu_rd_en = 1'b1; tick(); cpu_rd_en = 1'b0; tick();
    chk_b("R5 empty read valid", cpu_rd_valid, 1'b0);
    chk_b("R5 empty read rdy", pin_rdy_o, 1'b1);
    chk_b("R5 empty read done", xfer_done, 1'b0);
    // R9: writes ignored in receive mode
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h5A; tick(); cpu_wr_en = 1'b0; tick();
    chk_b("R9 rx busy", cpu_busy, 1'b0);
    chk_b("R9 rx dav_o", pin_dav_n_o, 1'b1);
    chk_b("R9 rx oe", pin_data_oe, 1'b0);
    chk_b("R9 rx err", cpu_wr_err, 1'b0);
    for (int v = 0; v < 256; v++) rx_xfer(8'(v), v % 5);

    // ---------------- send mode ----------------
    do_reset(1'b1);
    // R9: incoming strobe ignored in send mode
    pin_dav_n_i = 1'b0; pin_data_i = 8'hC3;
    repeat (5) begin
      tick();
      chk_b("R9 tx rd_valid", cpu_rd_valid, 1'b0);
      chk_b("R9 tx rdy_o", pin_rdy_o, 1'b0);
      chk_b("R9 tx done", xfer_done, 1'b0);
    end
    pin_dav_n_i = 1'b1;
    tick();
    for (int v = 0; v < 256; v++) tx_xfer(8'(v), v % 3, (v / 3) % 3);

    // R8: write while busy is rejected, flag sticky until cleared
    cpu_wr_en = 1'b1; cpu_wr_data = 8'hA5; tick();
    cpu_wr_en = 1'b0; tick();                        // N2: strobe low
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h3C; tick();   // N3
    cpu_wr_en = 1'b0;
    chk_b("R8 err set", cpu_wr_err, 1'b1);
    chk_v("R8 data kept", pin_data_o, 8'hA5);
    pin_rdy_i = 1'b0; repeat (3) tick();
    chk_b("R7 dav released", pin_dav_n_o, 1'b1);
    pin_rdy_i = 1'b1; repeat (3) tick();
    chk_b("R4 done after reject", xfer_done, 1'b1);
    chk_b("R7 busy clear", cpu_busy, 1'b0);
    chk_b("R8 err sticky", cpu_wr_err, 1'b1);
    chk_v("R8 data still kept", pin_data_o, 8'hA5);
    cpu_err_clr = 1'b1; tick(); cpu_err_clr = 1'b0;
    chk_b("R8 err cleared", cpu_wr_err, 1'b0);

    // R10: receiver not ready at the start
    pin_rdy_i = 1'b0; repeat (4) tick();
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h81; tick();
    cpu_wr_en = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      chk_b("R10 dav waits for ready", pin_dav_n_o, 1'b1);
      chk_b("R10 busy while waiting", cpu_busy, 1'b1);
      tick();
    end
    pin_rdy_i = 1'b1;                                // raised at Nb
    tick(); tick();
    chk_b("R10 dav not yet", pin_dav_n_o, 1'b1);
    tick();
    chk_b("R10 dav falls at b+3", pin_dav_n_o, 1'b0);
    pin_rdy_i = 1'b0; repeat (3) tick();
    chk_b("R7 dav rises", pin_dav_n_o, 1'b1);
    pin_rdy_i = 1'b1; repeat (3) tick();
    chk_b("R4 done R10 case", xfer_done, 1'b1);
    tick();
    chk_b("R4 done one cycle", xfer_done, 1'b0);
    finish_run();
  end

endmodule